// File: doc/BRIEF.md
# Page refresh rewrite scheduler

This block decides when pages of a 2048-page non-volatile array get rewritten in place. That way, no page goes too long without a refresh while its neighbours are being reprogrammed. It watches a one-cycle pulse for every finished page program, a pulse marking the end of a batch of programs, and the memory busy flag. It raises a rewrite request carrying a page number and a rewrite opcode. Then it holds that request until a completion pulse returns. Only after that does it issue another request.

A rotating refresh pointer picks the page. The pointer starts at page 0, wraps after the last page, and can step over the protected low region while that region is held protected. One shared counter of owed work serves three policies:

- **Per-program:** one rewrite follows each program.
- **Batch:** rewrites are deferred until the batch ends, then issued one for each counted program.
- **Sweep:** a whole-array pass runs once a threshold number of programs has accumulated.

Formatting the serial command is left to the consumer of the request.

Top module: `page_refresh_sched`

## Requirements
- R1: After reset no request is raised, `pass_done_o` is low, the policy is per-program (code 0), and the first page requested is page 0.
- R2: Under policy code 0, each `prog_done_i` pulse leads to exactly one rewrite at the pointer page, and the pointer then moves up by one.
- R3: Under policy code 1, programs are counted but no request is raised until a `batch_done_i` pulse. After that pulse, one rewrite per counted program is issued at consecutive pointer pages, and the count drops by one after each completion until it is zero.
- R4: Under policy code 2, once the program count reaches `THRESH`, the pointer returns to page 0 and every page is rewritten in order. The count is then reduced by `THRESH`.
- R5: A request is raised only in a cycle that follows a cycle with `mem_busy_i` low. Once raised, it stays high with a stable page and opcode until `rw_ack_i`.
- R6: The opcode is 8'h58 when `buf_sel_i` is 0 and 8'h59 when it is 1. `rw_page_o` carries the full page number.
- R7: While `prot_hold_i` is high, pages below `PROT_PAGES` are never requested: a pointer below that bound is served as page `PROT_PAGES`. A sweep started while protected rewrites only `PAGES-PROT_PAGES` pages.
- R8: After page `PAGES-1` is rewritten, the pointer returns to 0, and `pass_done_o` pulses for one cycle in the cycle after that completion.
- R9: Program pulses that arrive while a rewrite sequence is running are counted and later served; none is lost.
- R10: A new value on `policy_i` takes effect only while no request is pending or owed. Taking effect clears the counter. Code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Policy select: 0 per-program, 1 batch, 2 sweep |
| buf_sel_i | input | 1 | Buffer used for the rewrite (selects opcode) |
| prot_hold_i | input | 1 | Low region held protected; skip it |
| prog_done_i | input | 1 | One-cycle pulse per completed page program |
| batch_done_i | input | 1 | One-cycle pulse at the end of a program batch |
| mem_busy_i | input | 1 | Memory still busy with a program or erase |
| rw_ack_i | input | 1 | One-cycle pulse: requested rewrite finished |
| rw_req_o | output | 1 | Rewrite request, held until acknowledged |
| rw_op_o | output | 8 | Rewrite opcode for the selected buffer |
| rw_page_o | output | PW (11) | Page to rewrite |
| pass_done_o | output | 1 | Pulse when the pointer completes a pass |

## Verification
A wrong pointer shows at the first request after the fault, as a page that differs from the next page the bench computes arithmetically. The bench compares every requested page, so a skipped or repeated page is caught within one request. A miscounted work counter shows as a missing or extra request once the sequence drains. The bench therefore waits a fixed quiet window after every sequence, so a lost or invented unit of work is caught within that window. A wrong sweep threshold shows as a request appearing one program too early or not at all.

// File: rtl/pr_pkg.sv
package pr_pkg;
   typedef enum logic [1:0] {
      POL_EACH  = 2'd0,
      POL_BATCH = 2'd1,
      POL_SWEEP = 2'd2
   } pol_e;

   localparam logic [7:0] OP_RW_BUF0 = 8'h58;
   localparam logic [7:0] OP_RW_BUF1 = 8'h59;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_REQ  = 1'b1
   } st_e;
endpackage

// File: rtl/pr_page_ptr.sv
module pr_page_ptr #(
   parameter int PAGES      = 2048,
   parameter int PROT_PAGES = 256,
   parameter int PW         = $clog2(PAGES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prot_i,
   input  logic          load_zero_i,
   input  logic          adv_i,
   input  logic [PW-1:0] done_page_i,
   output logic [PW-1:0] eff_o,
   output logic          pass_o
);
   localparam logic [PW-1:0] LAST = PW'(PAGES - 1);

   logic [PW-1:0] ptr_q;
   logic          at_last;

   assign at_last = (done_page_i == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         pass_o <= 1'b0;
      end else begin
         pass_o <= adv_i && at_last;
         if (load_zero_i)
            ptr_q <= '0;
         else if (adv_i)
            ptr_q <= at_last ? '0 : done_page_i + 1'b1;
      end
   end

   generate
      if (PROT_PAGES > 0) begin : g_skip
         localparam logic [PW-1:0] PROT_V = PW'(PROT_PAGES);
         assign eff_o = (prot_i && (ptr_q < PROT_V)) ? PROT_V : ptr_q;
      end else begin : g_noskip
         assign eff_o = ptr_q;
      end
   endgenerate

   AST_PASS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> (ptr_q == '0)); // R8
   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !at_last |=> (ptr_q == $past(done_page_i) + 1'b1)); // R2
endmodule

// File: rtl/pr_op_counter.sv
module pr_op_counter #(
   parameter int THRESH = 10000,
   parameter int CW     = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_i,
   input  logic          dec_i,
   input  logic          sub_i,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o,
   output logic          at_thr_o
);
   localparam logic [CW-1:0] THR_V = CW'(THRESH);

   logic [CW-1:0] cnt_q, base, nxt;

   always_comb begin
      base = clr_i ? '0 : cnt_q;
      nxt  = base + CW'(inc_i) - CW'(dec_i) - (sub_i ? THR_V : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   assign cnt_o    = cnt_q;
   assign at_thr_o = (cnt_q >= THR_V);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i && !dec_i && !sub_i && !clr_i |-> (cnt_q != '1)); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |-> (cnt_q != '0)); // R3
   AST_SUB_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |-> (cnt_q >= THR_V)); // R4
endmodule

// File: rtl/page_refresh_sched.sv
module page_refresh_sched
   import pr_pkg::*;
#(
   parameter int PAGES      = 2048,
   parameter int PROT_PAGES = 256,
   parameter int THRESH     = 10000,
   parameter int PW         = $clog2(PAGES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    policy_i,
   input  logic          buf_sel_i,
   input  logic          prot_hold_i,
   input  logic          prog_done_i,
   input  logic          batch_done_i,
   input  logic          mem_busy_i,
   input  logic          rw_ack_i,
   output logic          rw_req_o,
   output logic [7:0]    rw_op_o,
   output logic [PW-1:0] rw_page_o,
   output logic          pass_done_o
);
   localparam int CW = $clog2(THRESH + PAGES) + 2;
   localparam logic [PW:0] ALL_N = (PW+1)'(PAGES);

   st_e           st_q;
   pol_e          pol_q;
   logic          rel_q;
   logic [PW:0]   swp_q;
   logic [PW-1:0] req_page_q;
   logic [7:0]    op_q;
   logic [CW-1:0] cnt;
   logic          at_thr;
   logic [PW-1:0] eff_page;
   logic [PW:0]   elig_n;
   logic          want, idle, pol_chg, go, fin, swp_start;

   generate
      if (PROT_PAGES > 0) begin : g_elig_prot
         localparam logic [PW:0] OPEN_N = (PW+1)'(PAGES - PROT_PAGES);
         assign elig_n = prot_hold_i ? OPEN_N : ALL_N;
      end else begin : g_elig_all
         assign elig_n = ALL_N;
      end
   endgenerate

   always_comb begin
      unique case (pol_q)
         POL_BATCH: want = rel_q && (cnt != '0);
         POL_SWEEP: want = (swp_q != '0);
         default:   want = (cnt != '0);
      endcase
   end

   assign idle      = (st_q == ST_IDLE) && !want;
   assign pol_chg   = idle && (policy_i != 2'd3) && (pol_e'(policy_i) != pol_q);
   assign go        = (st_q == ST_IDLE) && want && !mem_busy_i;
   assign fin       = (st_q == ST_REQ) && rw_ack_i;
   assign swp_start = (pol_q == POL_SWEEP) && (st_q == ST_IDLE) && (swp_q == '0)
                      && at_thr && !pol_chg;

   pr_op_counter #(.THRESH(THRESH), .CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (prog_done_i),
      .dec_i    (fin && (pol_q != POL_SWEEP)),
      .sub_i    (swp_start),
      .clr_i    (pol_chg),
      .cnt_o    (cnt),
      .at_thr_o (at_thr)
   );

   pr_page_ptr #(.PAGES(PAGES), .PROT_PAGES(PROT_PAGES), .PW(PW)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .prot_i      (prot_hold_i),
      .load_zero_i (swp_start),
      .adv_i       (fin),
      .done_page_i (req_page_q),
      .eff_o       (eff_page),
      .pass_o      (pass_done_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         pol_q      <= POL_EACH;
         rel_q      <= 1'b0;
         swp_q      <= '0;
         req_page_q <= '0;
         op_q       <= OP_RW_BUF0;
      end else begin
         if (go) begin
            st_q       <= ST_REQ;
            req_page_q <= eff_page;
            op_q       <= buf_sel_i ? OP_RW_BUF1 : OP_RW_BUF0;
         end else if (fin) begin
            st_q <= ST_IDLE;
         end

         if (pol_chg)
            pol_q <= pol_e'(policy_i);

         if (pol_chg)
            rel_q <= 1'b0;
         else if ((pol_q == POL_BATCH) && batch_done_i)
            rel_q <= 1'b1;
         else if (rel_q && (cnt == '0) && (st_q == ST_IDLE))
            rel_q <= 1'b0;

         if (pol_chg)
            swp_q <= '0;
         else if (swp_start)
            swp_q <= elig_n;
         else if (fin && (pol_q == POL_SWEEP))
            swp_q <= swp_q - 1'b1;
      end
   end

   assign rw_req_o  = (st_q == ST_REQ);
   assign rw_page_o = req_page_q;
   assign rw_op_o   = op_q;

   AST_ISSUE_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rw_req_o) |-> $past(!mem_busy_i)); // R5
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rw_req_o && !rw_ack_i |=> rw_req_o && $stable(rw_page_o) && $stable(rw_op_o)); // R5
   AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(pol_q)); // R10
   AST_BATCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == POL_BATCH) && !rel_q && (st_q == ST_IDLE) |=> !rw_req_o); // R3
   AST_OP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rw_req_o |-> (rw_op_o == OP_RW_BUF0) || (rw_op_o == OP_RW_BUF1)); // R6

   generate
      if (PROT_PAGES > 0) begin : g_prot_chk
         AST_PROT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rw_req_o) && $past(prot_hold_i)
            |-> (rw_page_o >= PW'(PROT_PAGES))); // R7
      end
   endgenerate
endmodule

// File: tb/page_refresh_sched_bench.sv
module page_refresh_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP   = 16;
   localparam int NPR  = 4;
   localparam int NTH  = 20;
   localparam int PW   = $clog2(NP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    policy_i = 2'd0;
   logic          buf_sel_i = 1'b0, prot_hold_i = 1'b0, prog_done_i = 1'b0;
   logic          batch_done_i = 1'b0, mem_busy_i = 1'b0, rw_ack_i = 1'b0;
   logic          rw_req_o, pass_done_o;
   logic [7:0]    rw_op_o;
   logic [PW-1:0] rw_page_o;

   int total = 0, bad = 0, exp_ptr = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   page_refresh_sched #(.PAGES(NP), .PROT_PAGES(NPR), .THRESH(NTH)) u_page_refresh_sched (
      .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .buf_sel_i(buf_sel_i),
      .prot_hold_i(prot_hold_i), .prog_done_i(prog_done_i), .batch_done_i(batch_done_i),
      .mem_busy_i(mem_busy_i), .rw_ack_i(rw_ack_i), .rw_req_o(rw_req_o),
      .rw_op_o(rw_op_o), .rw_page_o(rw_page_o), .pass_done_o(pass_done_o)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int eff(input int p);
      return (prot_hold_i && p < NPR) ? NPR : p;
   endfunction

   task automatic pulse_prog();
      prog_done_i = 1'b1; tick(); prog_done_i = 1'b0;
   endtask

   task automatic expect_quiet(input int n, input string tag);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         if (rw_req_o) seen = 1;
      end
      check(!seen, tag, int'(seen), 0);
   endtask

   task automatic serve(input string tag, input int hold, input int inject);
      int wait_n = 0;
      int ep;
      while (!rw_req_o && wait_n < 60) begin tick(); wait_n++; end
      check(rw_req_o, {tag, " request seen"}, int'(rw_req_o), 1);
      ep = eff(exp_ptr);
      check(int'(rw_page_o) == ep, {tag, " page"}, int'(rw_page_o), ep);
      check(rw_op_o == (buf_sel_i ? 8'h59 : 8'h58), "R6 opcode",
            int'(rw_op_o), buf_sel_i ? 'h59 : 'h58);
      for (int h = 0; h < hold; h++) begin
         if (h < inject) prog_done_i = 1'b1;
         tick();
         prog_done_i = 1'b0;
         check(rw_req_o && int'(rw_page_o) == ep, "R5 held until ack", int'(rw_page_o), ep);
      end
      rw_ack_i = 1'b1; tick(); rw_ack_i = 1'b0;
      check(pass_done_o == (ep == NP-1), "R8 pass pulse", int'(pass_done_o), int'(ep == NP-1));
      exp_ptr = (ep + 1) % NP;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state
      check(!rw_req_o, "R1 no request", int'(rw_req_o), 0);
      check(!pass_done_o, "R1 pass low", int'(pass_done_o), 0);
      expect_quiet(4, "R1 quiet after reset");

      // R2: per-program policy, first page 0 (R1)
      for (int k = 0; k < 3; k++) begin
         pulse_prog();
         serve("R2 each", 0, 0);
      end
      pulse_prog(); pulse_prog();
      serve("R9 back-to-back a", 0, 0);
      serve("R9 back-to-back b", 0, 0);
      expect_quiet(8, "R2 no extra rewrite");

      // R5: busy blocks issue; request held
      mem_busy_i = 1'b1;
      pulse_prog();
      expect_quiet(6, "R5 blocked while busy");
      // R10: change while work owed is refused
      policy_i = 2'd1;
      repeat (3) tick();
      mem_busy_i = 1'b0;
      serve("R10 policy kept while owed", 3, 0);
      repeat (3) tick();

      // R10: counter cleared on change (now batch)
      pulse_prog(); pulse_prog(); pulse_prog();
      policy_i = 2'd2; repeat (2) tick();
      policy_i = 2'd3; repeat (2) tick();
      policy_i = 2'd1; repeat (2) tick();
      batch_done_i = 1'b1; tick(); batch_done_i = 1'b0;
      expect_quiet(10, "R10 counter cleared");

      // R3 + R9: batch policy
      pulse_prog(); pulse_prog(); pulse_prog();
      expect_quiet(10, "R3 wait for batch end");
      batch_done_i = 1'b1; tick(); batch_done_i = 1'b0;
      buf_sel_i = 1'b1;
      serve("R3 batch 1", 2, 1);
      buf_sel_i = 1'b0;
      serve("R3 batch 2", 0, 0);
      serve("R3 batch 3", 0, 0);
      serve("R9 batch inject", 0, 0);
      expect_quiet(10, "R3 drained");

      // R8: wrap and pass pulse under per-program policy
      policy_i = 2'd0; repeat (2) tick();
      for (int k = 0; k < 20; k++) begin
         pulse_prog();
         serve("R8 wrap", 0, 0);
         if (exp_ptr == 0) break;
      end
      check(exp_ptr == 0, "R8 reached wrap", exp_ptr, 0);
      pulse_prog();
      serve("R8 after wrap", 0, 0);

      // R7: protected skip
      prot_hold_i = 1'b1;
      pulse_prog();
      serve("R7 skip low region", 0, 0);
      check(exp_ptr == NPR + 1, "R7 pointer after skip", exp_ptr, NPR + 1);
      prot_hold_i = 1'b0;
      repeat (2) tick();

      // R4: sweep policy
      policy_i = 2'd2; repeat (2) tick();
      for (int k = 0; k < NTH - 1; k++) pulse_prog();
      expect_quiet(10, "R4 below threshold");
      pulse_prog();
      exp_ptr = 0;
      for (int k = 0; k < NP; k++) serve("R4 sweep", (k < 2) ? 1 : 0, (k < 2) ? 1 : 0);
      expect_quiet(12, "R4 sweep complete");
      // R9 + R7: the two injected programs count toward the next sweep
      prot_hold_i = 1'b1;
      for (int k = 0; k < NTH - 3; k++) pulse_prog();
      expect_quiet(10, "R9 short by one");
      pulse_prog();
      exp_ptr = 0;
      for (int k = 0; k < NP - NPR; k++) serve("R7 protected sweep", 0, 0);
      expect_quiet(12, "R7 sweep length");
      prot_hold_i = 1'b0;
      summary();
   end
endmodule